// File: doc/BRIEF.md
# Dual 16-bit Reference-Compare Timer

This block holds two independent 16-bit up-counters that share one configuration byte on a simple synchronous register bus. Each counter advances on a tick from its own two-stage 8-bit prescaler. The source for that prescaler is either the core clock, the core clock divided by 16, or an external per-timer tick pulse. Software programs a reference value. When the counter reaches that value, the timer raises a match flag and can signal an interrupt. Depending on its mode, the counter then either restarts from zero or keeps counting.

Each timer also latches its counter into a capture register on a synchronized rising edge of its capture pin. The event flags are cleared by writing ones to them. The shared configuration byte holds, for each timer, a bit that releases it from reset and a bit that stops it. Software can therefore hold a timer in reset, freeze it to load the counter and reference, and then let it run.

Top module: `tmr_pair16`

## Requirements
- R1: Config register (address 0x7) bit 0 releases timer 0 from reset and bit 1 stops it. Bits 4 and 5 do the same for timer 1, and the other config bits read as zero. While a timer's release bit is 0, its counter, prescaler state and event flags are held at zero, counter writes and capture edges are ignored, and the stored capture value is kept. A timer counts only when its release bit is 1 and its stop bit is 0.
- R2: Timer n uses base address 8·n, with these offsets:
  - +0: mode (stored mask 0xFF1E).
  - +1: reference.
  - +2: capture (read only).
  - +3: counter.
  - +4: events (bit 0 capture, bit 1 match).
  - +5: primary prescale (low 8 bits stored).
  
  After reset every register reads zero and both interrupts are low.
- R3: Mode bits [2:1] choose the tick source:
  - 1: every clock.
  - 2: the clock divided by 16.
  - 0: one source tick per clock cycle in which the timer's `alt_tick` bit is high.
  - 3: no source, so the timer does not count.
  
  The counter advances once every (psr+1)·(sps+1) source ticks, where sps is mode bits [15:8]. With source 1, psr = 0 and sps = 0, a timer that is run for N clock edges advances by N.
- R4: With mode bit 3 set, a tick taken while the counter equals the reference loads zero.
- R5: With mode bit 3 clear, the counter increments past the reference and wraps from 0xFFFF to 0x0000.
- R6: The match flag (event bit 1) is set on a tick whose new counter value equals the reference.
- R7: Writing to the event register clears exactly the flags written as 1. A flag that is set in the same cycle as the clear stays set.
- R8: Output `irq[n]` is high exactly when timer n's match flag and its mode bit 4 are both 1.
- R9: A rising edge on `cap_in[n]` passes through a two-flop synchronizer. It then latches the current counter value into the capture register and sets event bit 0, so the new value is readable by the third clock edge after the pin rises.
- R10: Setting a timer's stop bit freezes its counter. While the timer is stopped, the counter and reference can be written and read back. A bus write to the counter takes priority over a tick.
- R11: The two timers are independent: running one leaves the other's counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| alt_tick | input | 2 | Alternate tick pulse per timer |
| cap_in | input | 2 | Capture pin per timer |
| irq | output | 2 | Match interrupt per timer |

## Verification
A reference match that sets the match flag and a software write-one-to-clear of that same flag can fall in the same clock cycle. The bench provokes this by running a timer in restart mode with a reference of zero, so that a match occurs on every tick. It issues the clear while the timer runs and judges the result by reading the flag back still set. It then stops the timer and repeats the clear, expecting the flag to drop. The prescaler sweep crosses both prescale stages with the slow path and compares the interval between interrupts against 16^slow·(psr+1)·(sps+1)·(ref+1).

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;
  localparam int CNT_W_DEF = 16;
  localparam int PS_W_DEF  = 8;

  localparam logic [1:0] CLK_ALT  = 2'd0;
  localparam logic [1:0] CLK_INT  = 2'd1;
  localparam logic [1:0] CLK_SLOW = 2'd2;
  localparam logic [1:0] CLK_OFF  = 2'd3;

  localparam logic [2:0] REG_MODE = 3'd0;
  localparam logic [2:0] REG_REF  = 3'd1;
  localparam logic [2:0] REG_CAP  = 3'd2;
  localparam logic [2:0] REG_CNT  = 3'd3;
  localparam logic [2:0] REG_EVT  = 3'd4;
  localparam logic [2:0] REG_PSR  = 3'd5;

  localparam logic [3:0] CFG_ADDR = 4'h7;

  typedef struct packed {
    logic [PS_W_DEF-1:0] sps;
    logic                irq_en;
    logic                restart;
    logic [1:0]          clk_sel;
  } tmr_mode_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pair_pkg::*;
#(
  parameter int PS_W   = 8,
  parameter int SLOW_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            run,
  input  logic [1:0]      clk_sel,
  input  logic [PS_W-1:0] psr,
  input  logic [PS_W-1:0] sps,
  input  logic            alt_tick,
  output logic            tick
);
  logic [SLOW_W-1:0] slow_q, slow_d;
  logic [PS_W-1:0]   p1_q, p1_d, p2_q, p2_d;
  logic              src_raw, src, stage1;

  always_comb begin
    slow_d = slow_q;
    if (run && clk_sel == CLK_SLOW) slow_d = slow_q + 1'b1;
    case (clk_sel)
      CLK_ALT:  src_raw = alt_tick;
      CLK_INT:  src_raw = 1'b1;
      CLK_SLOW: src_raw = &slow_q;
      default:  src_raw = 1'b0;
    endcase
    src    = src_raw && run;
    stage1 = src && (p1_q >= psr);
    p1_d   = p1_q;
    if (src) p1_d = stage1 ? '0 : p1_q + 1'b1;
    tick   = stage1 && (p2_q >= sps);
    p2_d   = p2_q;
    if (stage1) p2_d = tick ? '0 : p2_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= '0;
      p1_q   <= '0;
      p2_q   <= '0;
    end else if (hold) begin
      slow_q <= '0;
      p1_q   <= '0;
      p2_q   <= '0;
    end else begin
      slow_q <= slow_d;
      p1_q   <= p1_d;
      p2_q   <= p2_d;
    end
  end

  AST_INT_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !hold && clk_sel == CLK_INT && psr == '0 && sps == '0) |-> tick); // R3
  AST_NO_SOURCE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || clk_sel == CLK_OFF) |-> !tick); // R3
endmodule

// File: rtl/tmr_capsync.sv
module tmr_capsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], din};
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pair_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             release_bit,
  input  logic             stop_bit,
  input  logic             wr_en,
  input  logic [2:0]       reg_sel,
  input  logic [CNT_W-1:0] wdata,
  input  logic             alt_tick,
  input  logic             cap_in,
  output logic [CNT_W-1:0] rdata,
  output logic             irq
);
  localparam int EV_W = 2;

  tmr_mode_t        mode_q, mode_d;
  logic [CNT_W-1:0] ref_q, ref_d, cnt_q, cnt_d, cap_q, cap_d, cnt_step;
  logic [PS_W-1:0]  psr_q, psr_d;
  logic [EV_W-1:0]  ev_q, ev_d;
  logic we_mode, we_ref, we_cnt, we_evt, we_psr;
  logic run, tick, cap_rise, cap_set, match_set;

  assign run = release_bit & ~stop_bit;

  tmr_prescale #(.PS_W(PS_W), .SLOW_W(4)) i_prescale (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (~release_bit),
    .run      (run),
    .clk_sel  (mode_q.clk_sel),
    .psr      (psr_q),
    .sps      (mode_q.sps),
    .alt_tick (alt_tick),
    .tick     (tick)
  );

  tmr_capsync #(.STAGES(2)) i_capsync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cap_in),
    .rise  (cap_rise)
  );

  always_comb begin
    we_mode = wr_en && reg_sel == REG_MODE;
    we_ref  = wr_en && reg_sel == REG_REF;
    we_cnt  = wr_en && reg_sel == REG_CNT;
    we_evt  = wr_en && reg_sel == REG_EVT;
    we_psr  = wr_en && reg_sel == REG_PSR;

    mode_d = mode_q;
    if (we_mode) begin
      mode_d.sps     = wdata[15:8];
      mode_d.irq_en  = wdata[4];
      mode_d.restart = wdata[3];
      mode_d.clk_sel = wdata[2:1];
    end
    ref_d = we_ref ? wdata : ref_q;
    psr_d = we_psr ? wdata[PS_W-1:0] : psr_q;

    cnt_step  = (mode_q.restart && cnt_q == ref_q) ? '0 : cnt_q + 1'b1;
    match_set = tick && !we_cnt && (cnt_step == ref_q);
    cap_set   = cap_rise;

    cnt_d = cnt_q;
    if (we_cnt)    cnt_d = wdata;
    else if (tick) cnt_d = cnt_step;

    cap_d = cap_set ? cnt_q : cap_q;

    ev_d = ev_q;
    if (we_evt) ev_d = ev_q & ~wdata[EV_W-1:0];
    ev_d = ev_d | {match_set, cap_set};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '0;
      psr_q  <= '0;
    end else begin
      mode_q <= mode_d;
      ref_q  <= ref_d;
      psr_q  <= psr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ev_q  <= '0;
      cap_q <= '0;
    end else if (!release_bit) begin
      cnt_q <= '0;
      ev_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      ev_q  <= ev_d;
      cap_q <= cap_d;
    end
  end

  always_comb begin
    case (reg_sel)
      REG_MODE: rdata = {mode_q.sps, 3'b000, mode_q.irq_en, mode_q.restart,
                         mode_q.clk_sel, 1'b0};
      REG_REF:  rdata = ref_q;
      REG_CAP:  rdata = cap_q;
      REG_CNT:  rdata = cnt_q;
      REG_EVT:  rdata = {{(CNT_W-EV_W){1'b0}}, ev_q};
      REG_PSR:  rdata = {{(CNT_W-PS_W){1'b0}}, psr_q};
      default:  rdata = '0;
    endcase
  end

  assign irq = ev_q[1] & mode_q.irq_en;

  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !release_bit |=> (cnt_q == '0 && ev_q == '0)); // R1
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (release_bit && tick && !we_cnt && mode_q.restart && cnt_q == ref_q) |=> cnt_q == '0); // R4
  AST_FREE_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (release_bit && tick && !we_cnt && !mode_q.restart) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R5
  AST_W1C_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (release_bit && we_evt && wdata[1] && !match_set) |=> !ev_q[1]); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (release_bit && match_set) |=> ev_q[1]); // R7
  AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (release_bit && cap_rise) |=> (cap_q == $past(cnt_q) && ev_q[0])); // R9
  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (release_bit && stop_bit && !we_cnt) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/tmr_pair16.sv
module tmr_pair16
  import tmr_pair_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF,
  parameter int PS_W  = PS_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic [1:0]       alt_tick,
  input  logic [1:0]       cap_in,
  output logic [1:0]       irq
);
  localparam int          NTMR     = 2;
  localparam logic [7:0]  CFG_MASK = 8'h33;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [7:0]       cfg_q, cfg_d;
  logic [CNT_W-1:0] rd_tmr [NTMR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    cfg_d = cfg_q;
    if (bus_wr && bus_addr == CFG_ADDR) cfg_d = bus_wdata[7:0] & CFG_MASK;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) cfg_q <= '0;
    else             cfg_q <= cfg_d;
  end

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    tmr_channel #(.CNT_W(CNT_W), .PS_W(PS_W)) i_channel (
      .clk         (clk),
      .rst_n       (rst_core_n),
      .release_bit (cfg_q[4*g]),
      .stop_bit    (cfg_q[4*g+1]),
      .wr_en       (bus_wr && bus_addr[3] == 1'(g)),
      .reg_sel     (bus_addr[2:0]),
      .wdata       (bus_wdata),
      .alt_tick    (alt_tick[g]),
      .cap_in      (cap_in[g]),
      .rdata       (rd_tmr[g]),
      .irq         (irq[g])
    );
  end

  always_comb begin
    if (bus_addr == CFG_ADDR) bus_rdata = {{(CNT_W-8){1'b0}}, cfg_q};
    else                      bus_rdata = rd_tmr[bus_addr[3]];
  end
endmodule

// File: tb/test_tmr_pair16.sv
module test_tmr_pair16;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [1:0]  alt_tick;
  logic [1:0]  cap_in;
  logic [1:0]  irq;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  tmr_pair16 i_tmr_pair16 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_tick(alt_tick),
    .cap_in(cap_in), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, {16'h0, v}, {16'h0, exp});
  endtask

  task automatic wait_irq0(output int t, output bit ok);
    int n = 0;
    while (irq[0] !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    ok = (irq[0] === 1'b1);
    t  = cyc;
  endtask

  initial begin
    #(150000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int t1, t2;
    bit ok1, ok2;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    alt_tick = '0; cap_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R2 reset state
    rd_chk("R2 cfg reset", 4'h7, 16'h0000);
    rd_chk("R2 mode0 reset", 4'h0, 16'h0000);
    rd_chk("R2 cnt0 reset", 4'h3, 16'h0000);
    rd_chk("R2 evt1 reset", 4'hC, 16'h0000);
    chk("R2 irq reset", {30'h0, irq}, 32'h0);

    // R2 stored masks
    wr(4'h0, 16'hFFFF); rd_chk("R2 mode mask", 4'h0, 16'hFF1E);
    wr(4'h5, 16'hFFFF); rd_chk("R2 psr mask", 4'h5, 16'h00FF);
    wr(4'h7, 16'hFFFF); rd_chk("R1 cfg mask", 4'h7, 16'h0033);
    wr(4'h7, 16'h0000); wr(4'h0, 16'h0000); wr(4'h5, 16'h0000);

    // R1 held timer ignores counter write
    wr(4'h3, 16'h1234); rd_chk("R1 held cnt", 4'h3, 16'h0000);

    // R10 stopped: writes stick, counter frozen
    wr(4'h7, 16'h0003);
    wr(4'h0, 16'h0002);
    wr(4'h3, 16'h0010); wr(4'h1, 16'h0100);
    rd_chk("R10 cnt write", 4'h3, 16'h0010);
    rd_chk("R10 ref write", 4'h1, 16'h0100);
    idle(5);
    rd_chk("R10 stop freeze", 4'h3, 16'h0010);

    // R3/R5/R6 free run past ref
    wr(4'h1, 16'h0003); wr(4'h3, 16'h0000);
    wr(4'h7, 16'h0001); idle(6); wr(4'h7, 16'h0003);
    rd_chk("R3 R5 count past ref", 4'h3, 16'h0007);
    rd_chk("R6 match flag", 4'h4, 16'h0002);
    chk("R8 irq disabled", {31'h0, irq[0]}, 32'h0);
    wr(4'h0, 16'h0012);
    chk("R8 irq enabled", {31'h0, irq[0]}, 32'h1);
    wr(4'h4, 16'h0002);
    rd_chk("R7 clear match", 4'h4, 16'h0000);
    chk("R8 irq after clear", {31'h0, irq[0]}, 32'h0);

    // R5 wrap
    wr(4'h0, 16'h0002); wr(4'h1, 16'h0100); wr(4'h3, 16'hFFFE);
    wr(4'h7, 16'h0001); idle(2); wr(4'h7, 16'h0003);
    rd_chk("R5 wrap", 4'h3, 16'h0001);
    rd_chk("R6 no match", 4'h4, 16'h0000);

    // R4 restart
    wr(4'h0, 16'h000A); wr(4'h1, 16'h0002); wr(4'h3, 16'h0000);
    wr(4'h7, 16'h0001); idle(4); wr(4'h7, 16'h0003);
    rd_chk("R4 restart count", 4'h3, 16'h0002);
    rd_chk("R6 restart match", 4'h4, 16'h0002);
    wr(4'h4, 16'hFFFF);

    // R3 alternate source and no source
    wr(4'h0, 16'h0000); wr(4'h3, 16'h0000); wr(4'h1, 16'h0100);
    wr(4'h7, 16'h0001);
    for (int i = 0; i < 5; i++) begin
      alt_tick[0] = 1'b1; idle(1); alt_tick[0] = 1'b0; idle(2);
    end
    wr(4'h7, 16'h0003);
    rd_chk("R3 alt ticks", 4'h3, 16'h0005);
    wr(4'h0, 16'h0006);
    wr(4'h7, 16'h0001); idle(5); wr(4'h7, 16'h0003);
    rd_chk("R3 no source", 4'h3, 16'h0005);

    // R11 independence
    wr(4'h7, 16'h0033);
    wr(4'h3, 16'h0050); wr(4'h8, 16'h0002); wr(4'hB, 16'h0000);
    wr(4'h7, 16'h0013); idle(3); wr(4'h7, 16'h0033);
    rd_chk("R11 timer1 count", 4'hB, 16'h0004);
    rd_chk("R11 timer0 unchanged", 4'h3, 16'h0050);

    // R9 capture while stopped
    wr(4'h4, 16'hFFFF);
    cap_in[0] = 1'b1; idle(4); cap_in[0] = 1'b0; idle(4);
    rd_chk("R9 capture value", 4'h2, 16'h0050);
    rd_chk("R9 capture flag", 4'h4, 16'h0001);
    wr(4'h4, 16'h0002);
    rd_chk("R7 only ones clear", 4'h4, 16'h0001);
    wr(4'h4, 16'h0001);
    rd_chk("R7 capture cleared", 4'h4, 16'h0000);
    wr(4'h3, 16'h0077);
    cap_in[0] = 1'b1; idle(4); cap_in[0] = 1'b0; idle(4);
    rd_chk("R9 second capture", 4'h2, 16'h0077);
    wr(4'h7, 16'h0030);
    cap_in[0] = 1'b1; idle(4); cap_in[0] = 1'b0; idle(4);
    rd_chk("R1 capture ignored held", 4'h2, 16'h0077);

    // R7 set wins over clear in same cycle
    wr(4'h7, 16'h0003);
    wr(4'h0, 16'h000A); wr(4'h1, 16'h0000); wr(4'h3, 16'h0000);
    wr(4'h7, 16'h0001); idle(2);
    wr(4'h4, 16'h0002);
    rd_chk("R7 set beats clear", 4'h4, 16'h0002);
    wr(4'h7, 16'h0003);
    wr(4'h4, 16'h0002);
    rd_chk("R7 clear when idle", 4'h4, 16'h0000);

    // R3 prescaler sweep
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 3; p++) begin
        for (int q = 0; q < 3; q++) begin
          int sps_v, expv;
          sps_v = (q == 2) ? 3 : q;
          expv  = ((s == 1) ? 16 : 1) * (p + 1) * (sps_v + 1) * 4;
          wr(4'h7, 16'h0000);
          wr(4'h0, 16'((sps_v << 8) | 16'h0018 | ((s == 1) ? 16'h0004 : 16'h0002)));
          wr(4'h5, 16'(p));
          wr(4'h1, 16'h0003);
          wr(4'h7, 16'h0001);
          wait_irq0(t1, ok1);
          wr(4'h4, 16'h0002);
          wait_irq0(t2, ok2);
          chk($sformatf("R3 period slow=%0d psr=%0d sps=%0d", s, p, sps_v),
              (ok1 && ok2) ? 32'(t2 - t1) : 32'hFFFFFFFF, 32'(expv));
        end
      end
    end
    wr(4'h7, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule